// File: doc/BRIEF.md
# Debug Memory Access Port

This block connects a debug port's access-port register interface to a 32-bit system memory bus. The debugger reads and writes a small set of registers through one strobed register interface, made of an 8-bit offset, write data, read data, and separate write and read strobes. A control word sets the transfer size and the address auto-increment mode. A transfer address register holds the bus address. Any access to the data register, or to one of four banked data windows, starts one bus transfer. Sub-word data is moved onto the byte lanes that the low address bits select. Read data is moved back down to bit 0.

Reads of the data registers are posted. A read strobe on a data register returns the result of the most recent completed bus read and, in the same access, starts a new read. While a transfer waits for its acknowledge, the block reports itself busy. Data accesses made in that time are discarded, and a sticky flag records that this happened. An access that arrives in the same cycle as the acknowledge is accepted. After a data-register access, the transfer address moves forward by the access size or by 4, depending on the mode. The step never leaves the current 1 KB aligned region: only the low ten address bits wrap, and a sticky flag records the wrap.

Top module: `dbg_mem_ap`

## Requirements
- R1: Register map by offset. The control word is at 0x00 and the transfer address at 0x04. The data register is at 0x0C and the banked windows at 0x10/0x14/0x18/0x1C. Read-only words are at 0xF4 (configuration, parameter CFG_VAL), 0xF8 (base, parameter BASE_VAL) and 0xFC (identification, parameter ID_VAL). Writes to the read-only words have no effect, and any other offset reads 0.
- R2: Control word layout. Bits [2:0] hold the size (0 byte, 1 halfword, 2 word) and bits [5:4] the increment mode. Bit 7 is the boundary-wrap flag, bit 8 is busy (read-only), and bit 9 is the dropped-access flag. Bits 29, 25, 24 and 6 always read 1. After reset the control word reads 0x23000040 and the transfer address reads 0.
- R3: A control-word write with a size value of 3 to 7 leaves the stored size unchanged. The mode field is still written.
- R4: A write or read strobe at offset 0x0C starts exactly one bus transfer at the transfer address. The bus write-enable equals the strobe type.
- R5: Lane steering. A byte transfer enables only lane addr[1:0] and places data[7:0] there. A halfword transfer enables lanes 1:0 when addr[1] is 0 and lanes 3:2 when addr[1] is 1, and places data[15:0] there. A word transfer enables all four lanes with the data unchanged.
- R6: A data-register read returns the value captured by the previous completed bus read, which is 0 after reset. That value was taken from the lane or lanes given by the R5 mapping and zero-extended down to bit 0.
- R7: Mode 01 adds 1, 2 or 4 to the transfer address after each access at 0x0C, for byte, halfword and word size. Modes 00 and 11 leave the address unchanged.
- R8: Mode 10 adds 4 after each access at 0x0C, whatever the size.
- R9: An increment past the 1 KB boundary wraps bits [9:0] and keeps bits [31:10]. It sets control bit 7, which stays set until a control write with bit 7 = 1 clears it.
- R10: An access to the banked window at 0x10 + 4n uses bus address {TAR[31:4], n, 2'b00} and never changes the transfer address.
- R11: The bus request stays high until the acknowledge, with address, byte enables, write data and direction held steady. Control bit 8 reads 1 while the request is outstanding.
- R12: A data access made while a request is outstanding and unacknowledged starts no transfer and leaves the transfer address unchanged. It sets control bit 9, which a control write with bit 9 = 1 clears. A data access in the cycle of the acknowledge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the offset presented |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 32 | Bus byte address |
| bus_be_o | output | 4 | Bus byte-lane enables |
| bus_wdata_o | output | 32 | Bus write data, lane-steered |
| bus_ack_i | input | 1 | Bus acknowledge, completes the request |
| bus_rdata_i | input | 32 | Bus read data, valid with the acknowledge |

## Verification
The collision that matters is a new data-register access landing in the same cycle as the bus acknowledge of the transfer before it. In that cycle the block must both finish and capture the old transfer and launch the new one. The bench provokes it by making the bus model acknowledge on the first cycle of each request while issuing two data writes back to back. It then judges the outcome from the transfer count at the bus, a clear dropped flag, and a transfer address that has advanced twice. The contrasting case also gets a test: the same pair of writes against a slow acknowledge must leave exactly one transfer and a set dropped flag.

// File: rtl/dbg_ap_pkg.sv
package dbg_ap_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} xfer_size_e;
  typedef enum logic [1:0] {INC_OFF = 2'd0, INC_SINGLE = 2'd1, INC_PACKED = 2'd2, INC_RSVD = 2'd3} inc_mode_e;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TAR  = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h0C;
  localparam logic [7:0] OFF_CFG  = 8'hF4;
  localparam logic [7:0] OFF_BASE = 8'hF8;
  localparam logic [7:0] OFF_ID   = 8'hFC;

  localparam logic [31:0] CTRL_FIXED = 32'h2300_0040;
endpackage

// File: rtl/dbg_ap_incr.sv
module dbg_ap_incr
  import dbg_ap_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned WIN_BITS = 10
) (
  input  logic [AW-1:0] addr_i,
  input  xfer_size_e    size_i,
  input  inc_mode_e     mode_i,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o
);
  localparam int unsigned SW = WIN_BITS + 1;

  logic [2:0]    step;
  logic [SW-1:0] sum;

  always_comb begin
    case (mode_i)
      INC_SINGLE: begin
        case (size_i)
          SZ_BYTE: step = 3'd1;
          SZ_HALF: step = 3'd2;
          default: step = 3'd4;
        endcase
      end
      INC_PACKED: step = 3'd4;
      default:    step = 3'd0;
    endcase
  end

  // carry out of the window is reported, never propagated
  assign sum    = {1'b0, addr_i[WIN_BITS-1:0]} + SW'(step);
  assign addr_o = {addr_i[AW-1:WIN_BITS], sum[WIN_BITS-1:0]};
  assign wrap_o = sum[WIN_BITS];
endmodule

// File: rtl/dbg_ap_steer.sv
module dbg_ap_steer
  import dbg_ap_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  xfer_size_e      size_i,
  input  logic [1:0]      addr_lo_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   data_o
);
  localparam int unsigned NB = DW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic       be_l;
    logic [7:0] byte_l;
    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          be_l   = (addr_lo_i == 2'(i));
          byte_l = data_i[7:0];
        end
        SZ_HALF: begin
          be_l   = (addr_lo_i[1] == 1'(i / 2));
          byte_l = data_i[8*(i%2) +: 8];
        end
        default: begin
          be_l   = 1'b1;
          byte_l = data_i[8*i +: 8];
        end
      endcase
    end
    assign be_o[i]          = be_l;
    assign data_o[8*i +: 8] = be_l ? byte_l : 8'h00;
  end
endmodule

// File: rtl/dbg_ap_extract.sv
module dbg_ap_extract
  import dbg_ap_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  xfer_size_e    size_i,
  input  logic [1:0]    addr_lo_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = DW'(word_i[{addr_lo_i, 3'b000} +: 8]);
      SZ_HALF: data_o = DW'(word_i[{addr_lo_i[1], 4'b0000} +: 16]);
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/dbg_ap_bus.sv
module dbg_ap_bus
  import dbg_ap_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  xfer_size_e      size_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            ack_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW/8-1:0] be_o,
  output logic [DW-1:0]   wdata_o,
  output xfer_size_e      size_o,
  output logic [DW-1:0]   rd_data_o
);
  localparam int unsigned NB = DW / 8;

  logic [NB-1:0] be_n;
  logic [DW-1:0] wd_n;
  logic [DW-1:0] rd_ext;

  dbg_ap_steer #(.DW(DW)) u_steer (
    .size_i    (size_i),
    .addr_lo_i (addr_i[1:0]),
    .data_i    (wdata_i),
    .be_o      (be_n),
    .data_o    (wd_n)
  );

  // extraction uses the attributes of the transfer being completed
  dbg_ap_extract #(.DW(DW)) u_extract (
    .size_i    (size_o),
    .addr_lo_i (addr_o[1:0]),
    .word_i    (rdata_i),
    .data_o    (rd_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      we_o      <= 1'b0;
      addr_o    <= '0;
      be_o      <= '0;
      wdata_o   <= '0;
      size_o    <= SZ_BYTE;
      rd_data_o <= '0;
    end else begin
      if (ack_i && req_o && !we_o) rd_data_o <= rd_ext;
      if (start_i) begin
        req_o   <= 1'b1;
        we_o    <= we_i;
        addr_o  <= addr_i;
        be_o    <= be_n;
        wdata_o <= wd_n;
        size_o  <= size_i;
      end else if (ack_i) begin
        req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_mem_ap.sv
module dbg_mem_ap
  import dbg_ap_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned WIN_BITS = 10,
  parameter logic [31:0] CFG_VAL  = 32'h0000_0000,
  parameter logic [31:0] BASE_VAL = 32'hE00F_F003,
  parameter logic [31:0] ID_VAL   = 32'h2477_0011
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      reg_addr_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW/8-1:0] bus_be_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic            bus_ack_i,
  input  logic [DW-1:0]   bus_rdata_i
);
  localparam int unsigned NB = DW / 8;

  xfer_size_e    size_q;
  inc_mode_e     mode_q;
  logic          wrap_q;
  logic          drop_q;
  logic [AW-1:0] tar_q;

  logic          is_data, is_bank, data_acc, start, drop, busy, tar_wrap;
  logic [1:0]    bank_sel;
  logic [AW-1:0] xfer_addr, tar_nxt;
  logic [DW-1:0] rd_data, ctrl_view;
  xfer_size_e    xfer_size;

  assign is_data  = (reg_addr_i == OFF_DATA);
  assign is_bank  = (reg_addr_i[7:4] == 4'h1) && (reg_addr_i[1:0] == 2'b00);
  assign bank_sel = reg_addr_i[3:2];
  assign data_acc = (reg_wr_i | reg_rd_i) & (is_data | is_bank);
  assign start    = data_acc & (~busy | bus_ack_i);
  assign drop     = data_acc & busy & ~bus_ack_i;

  assign xfer_addr = is_bank ? {tar_q[AW-1:4], bank_sel, 2'b00} : tar_q;

  dbg_ap_incr #(.AW(AW), .WIN_BITS(WIN_BITS)) u_incr (
    .addr_i (tar_q),
    .size_i (size_q),
    .mode_i (mode_q),
    .addr_o (tar_nxt),
    .wrap_o (tar_wrap)
  );

  dbg_ap_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .we_i      (reg_wr_i),
    .addr_i    (xfer_addr),
    .size_i    (size_q),
    .wdata_i   (reg_wdata_i),
    .ack_i     (bus_ack_i),
    .rdata_i   (bus_rdata_i),
    .req_o     (busy),
    .we_o      (bus_we_o),
    .addr_o    (bus_addr_o),
    .be_o      (bus_be_o),
    .wdata_o   (bus_wdata_o),
    .size_o    (xfer_size),
    .rd_data_o (rd_data)
  );

  assign bus_req_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_BYTE;
      mode_q <= INC_OFF;
      wrap_q <= 1'b0;
      drop_q <= 1'b0;
      tar_q  <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == OFF_CTRL) begin
        if (reg_wdata_i[2:0] <= 3'd2) size_q <= xfer_size_e'(reg_wdata_i[1:0]);
        mode_q <= inc_mode_e'(reg_wdata_i[5:4]);
        if (reg_wdata_i[7]) wrap_q <= 1'b0;
        if (reg_wdata_i[9]) drop_q <= 1'b0;
      end
      if (reg_wr_i && reg_addr_i == OFF_TAR) tar_q <= reg_wdata_i[AW-1:0];
      if (start && is_data) begin
        tar_q <= tar_nxt;
        if (tar_wrap) wrap_q <= 1'b1;
      end
      if (drop) drop_q <= 1'b1;
    end
  end

  assign ctrl_view = CTRL_FIXED |
                     {22'b0, drop_q, busy, wrap_q, 1'b0, mode_q, 1'b0, 1'b0, size_q};

  always_comb begin
    if (is_data || is_bank) begin
      reg_rdata_o = rd_data;
    end else begin
      case (reg_addr_i)
        OFF_CTRL: reg_rdata_o = ctrl_view;
        OFF_TAR:  reg_rdata_o = DW'(tar_q);
        OFF_CFG:  reg_rdata_o = CFG_VAL;
        OFF_BASE: reg_rdata_o = BASE_VAL;
        OFF_ID:   reg_rdata_o = ID_VAL;
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  if (NB != 4) begin : g_width_check
    initial $error("dbg_mem_ap supports a 32-bit data path only");
  end
endmodule

// File: rtl/dbg_mem_ap_chk.sv
module dbg_mem_ap_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    reg_addr_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic          bus_req_o,
  input logic          bus_ack_i,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [3:0]    bus_be_o,
  input logic [31:0]   bus_wdata_o,
  input logic [1:0]    xfer_size,
  input logic [AW-1:0] tar,
  input logic          drop_flag
);
  logic strobe, at_data, at_bank;
  assign strobe  = reg_wr_i | reg_rd_i;
  assign at_data = reg_addr_i == 8'h0C;
  assign at_bank = (reg_addr_i == 8'h10) || (reg_addr_i == 8'h14) ||
                   (reg_addr_i == 8'h18) || (reg_addr_i == 8'h1C);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
                                && $stable(bus_wdata_o) && $stable(bus_we_o));

  // R11
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> $past(bus_ack_i));

  // R5
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && xfer_size == 2'd0 |-> $countones(bus_be_o) == 1);

  // R5
  half_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && xfer_size == 2'd1 |-> bus_be_o == 4'h3 || bus_be_o == 4'hC);

  // R5
  word_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && xfer_size == 2'd2 |-> bus_be_o == 4'hF);

  // R9
  window_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && at_data |=> tar[AW-1:10] == $past(tar[AW-1:10]));

  // R10
  bank_no_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && at_bank && !reg_wr_i |=> $stable(tar));

  // R12
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && (at_data || at_bank) && bus_req_o && !bus_ack_i |=> drop_flag && $stable(tar));
endmodule

bind dbg_mem_ap dbg_mem_ap_chk #(.AW(AW)) u_dbg_mem_ap_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .bus_req_o   (bus_req_o),
  .bus_ack_i   (bus_ack_i),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_be_o    (bus_be_o),
  .bus_wdata_o (bus_wdata_o),
  .xfer_size   (xfer_size),
  .tar         (tar_q),
  .drop_flag   (drop_q)
);

// File: tb/test_dbg_mem_ap.sv
module test_dbg_mem_ap;
  localparam logic [31:0] CFG_V  = 32'h0000_0000;
  localparam logic [31:0] BASE_V = 32'hE00F_F003;
  localparam logic [31:0] ID_V   = 32'h2477_0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [3:0]  bus_be;

  always #2 clk = ~clk;

  dbg_mem_ap i_dbg_mem_ap (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_be_o(bus_be),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // bus responder memory
  logic [31:0] mem [256];
  logic [31:0] mem_m [256];
  int          fixed_delay = -1;
  int          cnt = 0;
  int          n_xfers = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic        cap_we;

  function automatic logic [31:0] be_mask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (rst_n && bus_req) begin
      if (cnt <= 0) begin
        bus_ack   = 1'b1;
        cap_addr  = bus_addr;
        cap_be    = bus_be;
        cap_wdata = bus_wdata;
        cap_we    = bus_we;
        n_xfers++;
        if (bus_we)
          mem[bus_addr[9:2]] = (mem[bus_addr[9:2]] & ~be_mask(bus_be)) | (bus_wdata & be_mask(bus_be));
        bus_rdata = mem[bus_addr[9:2]];
        cnt = (fixed_delay >= 0) ? fixed_delay : int'($urandom % 4);
      end else begin
        cnt--;
      end
    end
  end

  // bench model
  logic [31:0] tar_m = '0, last_rd_m = '0;
  int          size_m = 0, mode_m = 0;
  bit          wrap_m = 0, drop_m = 0;

  function automatic logic [32:0] f_next(logic [31:0] t, int sz, int md);
    int          step;
    logic [10:0] s;
    step = (md == 1) ? (1 << sz) : (md == 2) ? 4 : 0;
    s = {1'b0, t[9:0]} + 11'(step);
    return {s[10], t[31:10], s[9:0]};
  endfunction

  function automatic logic [3:0] f_be(int sz, logic [1:0] a);
    if (sz == 0) return 4'b0001 << a;
    if (sz == 1) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] f_steer(int sz, logic [1:0] a, logic [31:0] d);
    if (sz == 0) return {24'b0, d[7:0]} << (8 * a);
    if (sz == 1) return {16'b0, d[15:0]} << (16 * a[1]);
    return d;
  endfunction

  function automatic logic [31:0] f_ext(int sz, logic [1:0] a, logic [31:0] w);
    if (sz == 0) return (w >> (8 * a)) & 32'hFF;
    if (sz == 1) return (w >> (16 * a[1])) & 32'hFFFF;
    return w;
  endfunction

  function automatic logic [31:0] f_ctrl();
    return 32'h2300_0040 | (32'(drop_m) << 9) | (32'(wrap_m) << 7) | (32'(mode_m) << 4) | 32'(size_m);
  endfunction

  // register port tasks: start and end at a falling edge
  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 40; k++) begin
      reg_read(8'h00, v);
      if (!v[8]) break;
    end
  endtask

  task automatic set_ctrl(input int sz, input int md, input logic [31:0] extra);
    reg_write(8'h00, extra | 32'(md << 4) | 32'(sz));
    if (sz <= 2) size_m = sz;
    mode_m = md;
    if (extra[7]) wrap_m = 0;
    if (extra[9]) drop_m = 0;
  endtask

  task automatic set_tar(input logic [31:0] t);
    reg_write(8'h04, t);
    tar_m = t;
  endtask

  // one data access, waited to completion and checked
  task automatic data_op(input bit wr, input int bank, input logic [31:0] d, input string req);
    logic [31:0] a, got, exp_w;
    logic [32:0] nx;
    logic [7:0]  off;
    int          x0;
    a   = (bank < 0) ? tar_m : {tar_m[31:4], 2'(bank), 2'b00};
    off = (bank < 0) ? 8'h0C : 8'(8'h10 + 4 * bank);
    x0  = n_xfers;
    if (wr) reg_write(off, d);
    else begin
      reg_read(off, got);
      chk(got == last_rd_m, {req, "/R6 posted read"}, got, last_rd_m);
    end
    wait_idle();
    chk(n_xfers == x0 + 1, {req, "/R4 one transfer"}, 32'(n_xfers - x0), 32'd1);
    chk(cap_addr == a && cap_we == wr, {req, "/R4 bus address"}, cap_addr, a);
    chk(cap_be == f_be(size_m, a[1:0]), {req, "/R5 byte enables"}, 32'(cap_be), 32'(f_be(size_m, a[1:0])));
    if (wr) begin
      exp_w = f_steer(size_m, a[1:0], d);
      chk((cap_wdata & be_mask(cap_be)) == exp_w, {req, "/R5 lane data"}, cap_wdata, exp_w);
      mem_m[a[9:2]] = (mem_m[a[9:2]] & ~be_mask(f_be(size_m, a[1:0]))) | exp_w;
    end else begin
      last_rd_m = f_ext(size_m, a[1:0], mem_m[a[9:2]]);
    end
    if (bank < 0) begin
      nx = f_next(tar_m, size_m, mode_m);
      tar_m = nx[31:0];
      if (nx[32]) wrap_m = 1;
    end
    reg_read(8'h04, got);
    chk(got == tar_m, {req, "/R7 transfer address"}, got, tar_m);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
      mem_m[i] = mem[i];
    end
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state and map
    chk(bus_req == 1'b0, "R11 no request after reset", 32'(bus_req), 32'd0);
    reg_read(8'h00, v); chk(v == 32'h2300_0040, "R2 reset control word", v, 32'h2300_0040);
    reg_read(8'h04, v); chk(v == 32'h0, "R2 reset transfer address", v, 32'h0);
    reg_read(8'hF4, v); chk(v == CFG_V, "R1 configuration word", v, CFG_V);
    reg_read(8'hF8, v); chk(v == BASE_V, "R1 base word", v, BASE_V);
    reg_write(8'hFC, 32'h1234_5678);
    reg_read(8'hFC, v); chk(v == ID_V, "R1 identification write ignored", v, ID_V);
    reg_read(8'h08, v); chk(v == 32'h0, "R1 unmapped offset", v, 32'h0);
    reg_read(8'h0C, v); chk(v == 32'h0, "R6 read data after reset", v, 32'h0);
    wait_idle();
    last_rd_m = f_ext(0, 2'b00, mem_m[0]);

    // R2 / R3 size encoding
    set_ctrl(2, 1, 32'h0);
    reg_read(8'h00, v); chk(v == 32'h2300_0052, "R2 word size single mode", v, 32'h2300_0052);
    reg_write(8'h00, 32'h0000_0017); mode_m = 1;
    reg_read(8'h00, v); chk(v == f_ctrl(), "R3 reserved size ignored", v, f_ctrl());

    // R9 window wrap with word steps
    set_tar(32'h1234_53F8);
    data_op(1, -1, 32'hCAFE_0001, "R9a");
    data_op(1, -1, 32'hCAFE_0002, "R9b");
    chk(tar_m == 32'h1234_5000, "R9 wrap keeps upper bits", tar_m, 32'h1234_5000);
    reg_read(8'h00, v); chk(v[7] == 1'b1, "R9 wrap flag set", v, f_ctrl());
    set_ctrl(2, 1, 32'h80);
    reg_read(8'h00, v); chk(v == f_ctrl(), "R9 wrap flag cleared", v, f_ctrl());

    // R5 byte and halfword lanes, R7 single increments
    set_ctrl(0, 1, 32'h0); set_tar(32'h0000_0100);
    for (int i = 0; i < 4; i++) data_op(1, -1, 32'h0000_0011 * 32'(i + 1), "R5 byte");
    set_ctrl(1, 1, 32'h0);
    for (int i = 0; i < 2; i++) data_op(1, -1, 32'h0000_BEE0 + 32'(i), "R5 half");
    set_ctrl(0, 1, 32'h0); set_tar(32'h0000_0100);
    for (int i = 0; i < 5; i++) data_op(0, -1, 32'h0, "R6 byte read");
    set_ctrl(1, 0, 32'h0);
    data_op(0, -1, 32'h0, "R7 mode off");
    set_ctrl(1, 3, 32'h0);
    data_op(0, -1, 32'h0, "R7 mode reserved");

    // R8 packed
    set_ctrl(0, 2, 32'h0); set_tar(32'h0000_0201);
    data_op(1, -1, 32'h0000_005A, "R8 packed byte");
    data_op(0, -1, 32'h0, "R8 packed read");

    // R10 banked windows
    set_ctrl(2, 1, 32'h0); set_tar(32'h0000_0338);
    for (int n = 0; n < 4; n++) data_op(1, n, 32'hB0B0_0000 | 32'(n), "R10 bank write");
    for (int n = 0; n < 4; n++) data_op(0, n, 32'h0, "R10 bank read");

    // R12 dropped access against a slow acknowledge
    begin
      int x0;
      fixed_delay = 6; cnt = 6; x0 = n_xfers;
      set_tar(32'h0000_0040);
      reg_write(8'h0C, 32'h1111_1111);
      reg_write(8'h0C, 32'h2222_2222);
      wait_idle();
      mem_m[16] = 32'h1111_1111;
      tar_m = 32'h0000_0044; drop_m = 1;
      chk(n_xfers == x0 + 1, "R12 busy access dropped", 32'(n_xfers - x0), 32'd1);
      reg_read(8'h04, v); chk(v == tar_m, "R12 address advanced once", v, tar_m);
      reg_read(8'h00, v); chk(v == f_ctrl(), "R12 drop flag set", v, f_ctrl());
      set_ctrl(2, 1, 32'h200);
      reg_read(8'h00, v); chk(v == f_ctrl(), "R12 drop flag cleared", v, f_ctrl());

      // R12 access in the acknowledge cycle is taken
      fixed_delay = 0; cnt = 0; x0 = n_xfers;
      reg_write(8'h0C, 32'h3333_3333);
      reg_write(8'h0C, 32'h4444_4444);
      wait_idle();
      mem_m[17] = 32'h3333_3333; mem_m[18] = 32'h4444_4444;
      tar_m = 32'h0000_004C;
      chk(n_xfers == x0 + 2, "R12 same-cycle access accepted", 32'(n_xfers - x0), 32'd2);
      chk(cap_addr == 32'h48 && cap_wdata == 32'h4444_4444, "R12 second transfer", cap_wdata, 32'h4444_4444);
      reg_read(8'h04, v); chk(v == tar_m, "R12 address advanced twice", v, tar_m);
      reg_read(8'h00, v); chk(v == f_ctrl(), "R12 no drop flagged", v, f_ctrl());
      fixed_delay = -1;
    end

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) set_ctrl(int'($urandom % 3), int'($urandom % 4), 32'h0);
      else if (r == 1) set_tar({$urandom} & 32'hFFFF_FC00 | (32'h3E0 + ($urandom % 32)));
      else if (r == 2) set_tar($urandom);
      else data_op(1'($urandom), (r < 5) ? int'($urandom % 4) : -1, $urandom, "R4 random");
    end
    reg_read(8'h00, v); chk(v == f_ctrl(), "R2 final control word", v, f_ctrl());

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule